// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the software-visible register file of a raster display controller. A host reaches it through a plain 32-bit word-indexed request/acknowledge bus with byte enables. It holds the base address of the frame buffer, two control bits (display on and upside-down scan), and an interrupt enable with its status flag. It drives those settings straight to the fetch and timing logic. Clearing the display-on bit holds the rest of the controller in reset.

A vertical-sync level arrives from the timing generator, already synchronised to this clock. Each low-to-high change of that level marks the end of a frame, which is also the point where the fetch logic takes the new base address. On that edge the block sets a status flag and, when enabled, emits a one-cycle interrupt pulse. Software acknowledges the frame by writing a new base address, which clears the flag.

Only whole-word accesses are accepted. A write with any byte lane off is dropped. A read with any byte lane off returns zero and raises an error.

Top module: `disp_regbank`

## Requirements
- R1: After reset the base register reads 0xF0000000 (the upper 11 bits of the default base), the control register reads 0x1 and the interrupt register reads 0x0; `disp_en_o`=1, `rev_scan_o`=0, `irq_o`=0.
- R2: The base register sits at word index 0. Only data bits 31..21 are stored; bits 20..0 always read as zero and `base_addr_o` equals the read value.
- R3: The control register sits at word index 1. Bit 0 is display enable (`disp_en_o`) and bit 1 is reverse scan (`rev_scan_o`); all other bits read zero.
- R4: The interrupt register sits at word index 2. Bit 3 is the interrupt enable and is writable. Bit 0 is the frame-done status and is not changed by writes to this register. Other bits read zero.
- R5: A rising edge of `vsync_in` sets the status bit.
- R6: Any full-word write to the base register clears the status bit. If a rising edge of `vsync_in` is seen in the same cycle, the status bit is set instead.
- R7: On a rising edge of `vsync_in` with the enable set, `irq_o` is high for exactly one cycle, in the cycle after the edge is sampled. With the enable clear, `irq_o` stays low.
- R8: A write whose byte enables are not all ones (`bus_be` != 4'hF) changes no register.
- R9: A read whose byte enables are not all ones returns zero with `bus_err`=1. A full read returns `bus_err`=0.
- R10: Word index 3 is reserved. Writes to it change nothing and reads return zero.
- R11: `core_rst_n_o` is low whenever `rst_n` is low or the display enable bit is 0.
- R12: Every request cycle is answered by `bus_ack` high for exactly one cycle on the following cycle, with `bus_rdata`/`bus_err` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 2 | Register word index (0 base, 1 control, 2 interrupt, 3 reserved) |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_err | output | 1 | Error on partial-width read, valid with acknowledge |
| vsync_in | input | 1 | Synchronised vertical sync level |
| base_addr_o | output | 32 | Frame buffer base address |
| rev_scan_o | output | 1 | Reverse (180-degree) scan select |
| disp_en_o | output | 1 | Display enable |
| core_rst_n_o | output | 1 | Active-low reset for the rest of the controller |
| irq_o | output | 1 | Frame-done interrupt pulse |

## Verification
A corrupted base or control register appears on `base_addr_o`, `rev_scan_o`, `disp_en_o` and `core_rst_n_o` in the cycle after the offending write. The bench also reads every register back on the next access. A wrong status flag stays hidden until a read of word index 2, so the bench reads it after each edge, each clearing write and the same-cycle collision. A missing, doubled or ungated interrupt pulse shows on `irq_o` within one cycle of the sampled edge. The bench samples it in that cycle and in the next.

// File: rtl/disp_reg_pkg.sv
// Package: shared word indices and bit positions of the display register file.
// Assumes a 32-bit data path addressed by word index.
package disp_reg_pkg;
    localparam int IDX_W    = 2;
    localparam logic [IDX_W-1:0] IDX_BASE = 2'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL = 2'd1;
    localparam logic [IDX_W-1:0] IDX_INTR = 2'd2;
    localparam logic [IDX_W-1:0] IDX_RSVD = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_REV_BIT = 1;
    localparam int INTR_ST_BIT  = 0;
    localparam int INTR_IE_BIT  = 3;
endpackage

// File: rtl/disp_vsync_edge.sv
// Module: detects the low-to-high change of the synchronised vsync level.
// Assumes vsync_in is already in this clock domain; rise_o is combinational.
module disp_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    output logic rise_o
);
    logic vs_q;

    // Hold the previous vsync sample.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync_in;
    end

    assign rise_o = vsync_in & ~vs_q;
endmodule

// File: rtl/disp_reg_store.sv
// Module: storage for base, control and interrupt state, plus the interrupt pulse.
// Assumes wr_en is already qualified with a full set of byte enables.
module disp_reg_store #(
    parameter int          DATA_W    = 32,
    parameter int          BASE_BITS = 11,
    parameter logic [31:0] DEF_BASE  = 32'hF000_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [disp_reg_pkg::IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           vs_rise,
    output logic [BASE_BITS-1:0]           base_o,
    output logic                           en_o,
    output logic                           rev_o,
    output logic                           ie_o,
    output logic                           stat_o,
    output logic                           irq_o
);
    import disp_reg_pkg::*;

    localparam logic [BASE_BITS-1:0] BASE_RST = DEF_BASE[31 -: BASE_BITS];

    logic wr_base, wr_ctrl, wr_intr;
    assign wr_base = wr_en && (wr_idx == IDX_BASE);
    assign wr_ctrl = wr_en && (wr_idx == IDX_CTRL);
    assign wr_intr = wr_en && (wr_idx == IDX_INTR);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // Base address register: upper bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_o <= BASE_RST;
        else if (wr_base) base_o <= wdata[DATA_W-1 -: BASE_BITS];
    end

    // Control register: display enable and reverse scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b1;
            rev_o <= 1'b0;
        end else if (wr_ctrl) begin
            en_o  <= wdata[CTRL_EN_BIT];
            rev_o <= wdata[CTRL_REV_BIT];
        end
    end

    // Interrupt enable: written through the interrupt register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_o <= 1'b0;
        else if (wr_intr) ie_o <= wdata[INTR_IE_BIT];
    end

    // Frame-done status: set by a vsync edge, which wins over a clearing base write.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_o <= 1'b0;
        else if (vs_rise) stat_o <= 1'b1;
        else if (wr_base) stat_o <= 1'b0;
    end

    // Interrupt pulse: one cycle per gated vsync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= vs_rise & ie_o;
    end
endmodule

// File: rtl/disp_bus_resp.sv
// Module: registered bus response; read mux, acknowledge and width error.
// Assumes one request per cycle and reads of the state present before any same-edge write.
module disp_bus_resp #(
    parameter int DATA_W    = 32,
    parameter int BASE_BITS = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req,
    input  logic                           we,
    input  logic                           full_be,
    input  logic [disp_reg_pkg::IDX_W-1:0] idx,
    input  logic [BASE_BITS-1:0]           base_i,
    input  logic                           en_i,
    input  logic                           rev_i,
    input  logic                           ie_i,
    input  logic                           stat_i,
    output logic                           ack_o,
    output logic [DATA_W-1:0]              rdata_o,
    output logic                           err_o
);
    import disp_reg_pkg::*;

    localparam int LOW_BITS = DATA_W - BASE_BITS;

    logic [DATA_W-1:0] rd_word;

    // Select the addressed register image.
    always_comb begin
        rd_word = '0;
        case (idx)
            IDX_BASE: rd_word = {base_i, {LOW_BITS{1'b0}}};
            IDX_CTRL: begin
                rd_word[CTRL_EN_BIT]  = en_i;
                rd_word[CTRL_REV_BIT] = rev_i;
            end
            IDX_INTR: begin
                rd_word[INTR_ST_BIT] = stat_i;
                rd_word[INTR_IE_BIT] = ie_i;
            end
            default: rd_word = '0;
        endcase
    end

    // Register the acknowledge, data and error one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            ack_o   <= req;
            rdata_o <= (req && !we && full_be) ? rd_word : '0;
            err_o   <= req && !we && !full_be;
        end
    end
endmodule

// File: rtl/disp_regbank.sv
// Module: top of the display register and interrupt block.
// Assumes vsync_in is synchronised to clk and accesses are whole 32-bit words.
module disp_regbank #(
    parameter int          DATA_W    = 32,
    parameter int          BASE_BITS = 11,
    parameter logic [31:0] DEF_BASE  = 32'hF000_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_req,
    input  logic                           bus_we,
    input  logic [disp_reg_pkg::IDX_W-1:0] bus_widx,
    input  logic [DATA_W/8-1:0]            bus_be,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic                           bus_ack,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           bus_err,
    input  logic                           vsync_in,
    output logic [DATA_W-1:0]              base_addr_o,
    output logic                           rev_scan_o,
    output logic                           disp_en_o,
    output logic                           core_rst_n_o,
    output logic                           irq_o
);
    localparam int LOW_BITS = DATA_W - BASE_BITS;

    logic                 full_be, wr_fire, vs_rise;
    logic [BASE_BITS-1:0] base_w;
    logic                 ien_w, stat_w;

    assign full_be = &bus_be;
    assign wr_fire = bus_req && bus_we && full_be;

    disp_vsync_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync_in (vsync_in),
        .rise_o   (vs_rise)
    );

    disp_reg_store #(
        .DATA_W    (DATA_W),
        .BASE_BITS (BASE_BITS),
        .DEF_BASE  (DEF_BASE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_idx  (bus_widx),
        .wdata   (bus_wdata),
        .vs_rise (vs_rise),
        .base_o  (base_w),
        .en_o    (disp_en_o),
        .rev_o   (rev_scan_o),
        .ie_o    (ien_w),
        .stat_o  (stat_w),
        .irq_o   (irq_o)
    );

    disp_bus_resp #(
        .DATA_W    (DATA_W),
        .BASE_BITS (BASE_BITS)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .full_be (full_be),
        .idx     (bus_widx),
        .base_i  (base_w),
        .en_i    (disp_en_o),
        .rev_i   (rev_scan_o),
        .ie_i    (ien_w),
        .stat_i  (stat_w),
        .ack_o   (bus_ack),
        .rdata_o (bus_rdata),
        .err_o   (bus_err)
    );

    assign base_addr_o  = {base_w, {LOW_BITS{1'b0}}};
    assign core_rst_n_o = rst_n & disp_en_o;
endmodule

// File: rtl/disp_regs_chk.sv
// Module: property checker bound to disp_regbank.
// Assumes the synchronous active-low reset of the block it watches.
module disp_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_we,
    input logic [3:0] bus_be,
    input logic       bus_ack,
    input logic       bus_err,
    input logic       vsync_in,
    input logic [31:0] base_addr_o,
    input logic       rev_scan_o,
    input logic       disp_en_o,
    input logic       core_rst_n_o,
    input logic       irq_o,
    input logic       ien,
    input logic       stat
);
    assert_ack_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);
    assert_no_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);
    assert_err_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_be != 4'hF) |=> bus_err);
    assert_err_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !bus_err);
    assert_rise_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_in) |=> stat);
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ien));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_partial_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_be != 4'hF) |=>
        ($stable(base_addr_o) && $stable(disp_en_o) && $stable(rev_scan_o) && $stable(ien)));
    assert_core_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_o |-> !core_rst_n_o);
endmodule

bind disp_regbank disp_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_be       (bus_be),
    .bus_ack      (bus_ack),
    .bus_err      (bus_err),
    .vsync_in     (vsync_in),
    .base_addr_o  (base_addr_o),
    .rev_scan_o   (rev_scan_o),
    .disp_en_o    (disp_en_o),
    .core_rst_n_o (core_rst_n_o),
    .irq_o        (irq_o),
    .ien          (ien_w),
    .stat         (stat_w)
);

// File: tb/sim_disp_regbank.sv
`timescale 1ns/1ps
module sim_disp_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_widx = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        vsync_in = 1'b0;
    logic [31:0] base_addr_o;
    logic        rev_scan_o, disp_en_o, core_rst_n_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd_v;
    logic        er_v;

    always #4 clk = ~clk;

    disp_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_widx(bus_widx), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .vsync_in(vsync_in), .base_addr_o(base_addr_o), .rev_scan_o(rev_scan_o),
        .disp_en_o(disp_en_o), .core_rst_n_o(core_rst_n_o), .irq_o(irq_o)
    );

    // Vector: {we, widx, be, wdata, expected rdata, expected err}
    localparam int NV = 16;
    localparam int VW = 72;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 2'd0, 4'hF, 32'h0,        32'hF000_0000, 1'b0}, // R1
        {1'b0, 2'd1, 4'hF, 32'h0,        32'h0000_0001, 1'b0}, // R1
        {1'b0, 2'd2, 4'hF, 32'h0,        32'h0000_0000, 1'b0}, // R1
        {1'b1, 2'd0, 4'hF, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R2
        {1'b0, 2'd0, 4'hF, 32'h0,        32'hFFE0_0000, 1'b0}, // R2
        {1'b1, 2'd0, 4'h3, 32'h0,        32'h0,         1'b0}, // R8
        {1'b0, 2'd0, 4'hF, 32'h0,        32'hFFE0_0000, 1'b0}, // R8
        {1'b1, 2'd1, 4'hF, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R3
        {1'b0, 2'd1, 4'hF, 32'h0,        32'h0000_0003, 1'b0}, // R3
        {1'b1, 2'd3, 4'hF, 32'h1234_5678, 32'h0,        1'b0}, // R10
        {1'b0, 2'd3, 4'hF, 32'h0,        32'h0,         1'b0}, // R10
        {1'b0, 2'd1, 4'h8, 32'h0,        32'h0,         1'b1}, // R9
        {1'b1, 2'd2, 4'hF, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R4
        {1'b0, 2'd2, 4'hF, 32'h0,        32'h0000_0008, 1'b0}, // R4
        {1'b1, 2'd1, 4'hF, 32'h0,        32'h0,         1'b0}, // R3
        {1'b0, 2'd1, 4'hF, 32'h0,        32'h0000_0000, 1'b0}  // R3
    };
    string VTAG [NV] = '{"R1","R1","R1","R2","R2","R8","R8","R3","R3",
                         "R10","R10","R9","R4","R4","R3","R3"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; checks the one-cycle acknowledge (R12) and returns data and error.
    task automatic bus_op(input logic we, input logic [1:0] idx, input logic [3:0] be,
                          input logic [31:0] d, input logic vs,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_widx = idx; bus_be = be; bus_wdata = d;
        vsync_in = vs;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R12 ack", {31'b0, bus_ack}, 32'h1);
        rd = bus_rdata;
        er = bus_err;
        @(negedge clk);
        chk("R12 ack drop", {31'b0, bus_ack}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R11: reset state at the ports
        chk("R1 base", base_addr_o, 32'hF000_0000);
        chk("R1 en", {31'b0, disp_en_o}, 32'h1);
        chk("R1 rev", {31'b0, rev_scan_o}, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R11 core rst released", {31'b0, core_rst_n_o}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            bus_op(v[71], v[70:69], v[68:65], v[64:33], 1'b0, rd_v, er_v);
            if (!v[71]) chk(VTAG[i], rd_v, v[32:1]);
            chk({VTAG[i], " err"}, {31'b0, er_v}, {31'b0, v[0]});
        end

        // R11 / R3: enable cleared by last vectors
        chk("R11 core in reset", {31'b0, core_rst_n_o}, 32'h0);
        chk("R3 en off", {31'b0, disp_en_o}, 32'h0);
        bus_op(1'b1, 2'd1, 4'hF, 32'h3, 1'b0, rd_v, er_v);
        chk("R3 en on", {31'b0, disp_en_o}, 32'h1);
        chk("R3 rev on", {31'b0, rev_scan_o}, 32'h1);
        chk("R11 core released", {31'b0, core_rst_n_o}, 32'h1);
        chk("R2 base port", base_addr_o, 32'hFFE0_0000);

        // R5 / R7: vsync edge with interrupt enabled
        @(negedge clk); vsync_in = 1'b1;
        @(negedge clk);
        chk("R7 irq pulse", {31'b0, irq_o}, 32'h1);
        vsync_in = 1'b0;
        @(negedge clk);
        chk("R7 irq single", {31'b0, irq_o}, 32'h0);
        bus_op(1'b0, 2'd2, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        chk("R5 status set", rd_v, 32'h9);

        // R6: base write clears status
        bus_op(1'b1, 2'd0, 4'hF, 32'h0020_0000, 1'b0, rd_v, er_v);
        bus_op(1'b0, 2'd2, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        chk("R6 status cleared", rd_v, 32'h8);
        bus_op(1'b0, 2'd0, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        chk("R2 base readback", rd_v, 32'h0020_0000);

        // R6: same-cycle vsync edge and base write, set wins
        bus_op(1'b1, 2'd0, 4'hF, 32'h8000_0000, 1'b1, rd_v, er_v);
        vsync_in = 1'b0;
        bus_op(1'b0, 2'd2, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        chk("R6 set wins", rd_v, 32'h9);
        chk("R2 base port", base_addr_o, 32'h8000_0000);

        // R4 / R7: disable interrupt; status untouched by this write; edge gives no pulse
        bus_op(1'b1, 2'd2, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        bus_op(1'b0, 2'd2, 4'hF, 32'h0, 1'b0, rd_v, er_v);
        chk("R4 status kept", rd_v, 32'h1);
        @(negedge clk); vsync_in = 1'b1;
        @(negedge clk);
        chk("R7 irq gated", {31'b0, irq_o}, 32'h0);
        vsync_in = 1'b0;
        @(negedge clk);
        chk("R7 irq gated late", {31'b0, irq_o}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule